// File: doc/BRIEF.md
# Segmented Address Map Translator

This block turns a 32-bit host or debug address into a physical memory address. The top byte of the address picks a segment. Three segments pass straight through to physical unified, instruction or data memory. Two segments are logical spaces: one for data, one for instructions. A logical address is translated through a small table of map registers, and each map register steers a fixed-size block of the logical space to a chosen place in physical memory.

With each address comes a requested byte count. The block grants the largest part of it that stays inside the current block or segment, so a caller can split a long transfer at the boundaries the block reports. An address that no segment or map entry covers raises a fault, and the grant is then zero.

The map registers live inside the block. They are written through a small register window near the top of data-memory addressing, and one data map register has a second address in that window. The register values after reset come from a strap input that picks between the normal set and a legacy set. Translation is purely combinational. A map write takes effect on the clock edge that accepts it.

Top module: `seg_xlate`

## Requirements
- R1: Address bits 31:24 select the segment. Selectors 0x00, 0x01 and 0x02 are physical unified, instruction and data memory: there is no fault and the output address equals the input address. Selectors 0x10 (logical data) and 0x11 (logical instruction) translate. Every other selector faults.
- R2: In the three physical segments the grant is the smaller of the request and the bytes left up to the next 128 KB segment boundary.
- R3: In the logical data space the offset (bits 23:0) is split into 16 KB blocks. Block k uses data map k (k = 0..3), and an offset of 0x10000 or more faults. The grant never runs past the end of the block.
- R4: When bit 15 of a data map is clear, bits 13:12 pick the target and bits 9:0 give the segment s. The targets are: 00 unified at s*16K + offset; 01 instruction at 0x01000000 + s*16K + offset; 10 data at 0x02000000 + (s<<16) + k*16K + offset; 11 faults.
- R5: When bit 15 of a data map is set, the access goes to I/O space. With q = in-block offset bits 13:12, the map nibble at bits [4*(3-q)+3 : 4*(3-q)] gives n, and the output address is 0x02000000 + n*0x10000 + 0xC000 + in-block offset.
- R6: In the logical instruction space the offset is split into 128 KB blocks. Block k uses instruction map k (k = 0..1), and an offset of 0x40000 or more faults. Map bits 13:12 pick the target and bits 6:0 give the segment s: 00 unified at (s<<17) + offset; 01 instruction at 0x01000000 + k*128K + offset; 10 faults. The grant never runs past the end of the block.
- R7: Instruction map target 11 is a test alias. It maps to 0x01000000 + (offset mod 0x800), and the grant never runs past the next 0x800 boundary.
- R8: While the fault output is high, the output address and the grant are both zero.
- R9: A write with the write enable high updates the map at the window address on the next clock edge. The window addresses are 0xFF00 and 0xFF02 for instruction maps 0 and 1, and 0xFF08, 0xFF0A, 0xFF0C and 0xFF0E for data maps 0 to 3.
- R10: A write to 0xFF04 updates data map 2, just as a write to 0xFF0C does. A write to any other address, and a cycle without the enable, leaves every map unchanged.
- R11: A clock edge with the strap low and rst_n low loads instruction maps 0x1000 and 0x1000 and data maps 0x2000, 0x2000, 0x2000 and 0x0000.
- R12: A clock edge with the strap high and rst_n low loads instruction maps 0x0000 and 0x007F and data maps 0x2000, 0x2000, 0x0000 and 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the map registers |
| legacy_i | input | 1 | Strap selecting the legacy set of reset values |
| addr_i | input | 32 | Address to translate |
| len_i | input | 18 | Requested byte count |
| wr_en_i | input | 1 | Map register write enable |
| wr_addr_i | input | 16 | Register window address of the write |
| wr_data_i | input | 16 | Map register write data |
| phys_o | output | 32 | Translated physical address |
| grant_o | output | 18 | Granted byte count |
| fault_o | output | 1 | Unsupported address |

## Verification
A corrupted map register stays hidden until an address falls in the block it covers. Once one does, the same cycle shows a wrong target address, a spurious fault or a wrong grant. A window decode error shows up one edge after the write, as a changed translation in some other block. For that reason the bench follows every directed write by probing all six blocks. The bench also mixes random map contents, including stray window addresses, with random addresses across all segments, so that a stale register is hit soon after it goes wrong. Errors in the boundary clamp appear only when the request is long enough to cross a boundary, so long requests and offsets just below each boundary are driven on purpose.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int NUM_DMAP = 4;
    localparam int NUM_IMAP = 2;
    localparam int MAP_W    = 16;

    // segment selectors in address bits 31:24
    localparam logic [7:0] SEL_PHYS_UNI = 8'h00;
    localparam logic [7:0] SEL_PHYS_INS = 8'h01;
    localparam logic [7:0] SEL_PHYS_DAT = 8'h02;
    localparam logic [7:0] SEL_LOG_DAT  = 8'h10;
    localparam logic [7:0] SEL_LOG_INS  = 8'h11;

    localparam logic [31:0] BASE_UNI  = 32'h0000_0000;
    localparam logic [31:0] BASE_INS  = 32'h0100_0000;
    localparam logic [31:0] BASE_DAT  = 32'h0200_0000;
    localparam logic [31:0] IO_WINDOW = 32'h0000_C000;

    // register window inside data memory
    localparam logic [15:0] WIN_IMAP        = 16'hFF00;
    localparam logic [15:0] WIN_DMAP        = 16'hFF08;
    localparam logic [15:0] WIN_DMAP2_ALIAS = 16'hFF04;
    localparam int          ALIAS_IDX       = 2;

    typedef logic [MAP_W-1:0] map_word_t;

    typedef struct packed {
        map_word_t [NUM_IMAP-1:0] imap;
        map_word_t [NUM_DMAP-1:0] dmap;
    } map_file_t;

    // one translation path result: room = bytes left to the boundary
    typedef struct packed {
        logic        fault;
        logic [31:0] phys;
        logic [31:0] room;
    } xlate_t;

    function automatic map_file_t boot_maps(input logic legacy);
        map_file_t m;
        m.dmap[0] = 16'h2000;
        m.dmap[1] = 16'h2000;
        m.dmap[3] = 16'h0000;
        if (legacy) begin
            m.imap[0] = 16'h0000;
            m.imap[1] = 16'h007F;
            m.dmap[2] = 16'h0000;
        end else begin
            m.imap[0] = 16'h1000;
            m.imap[1] = 16'h1000;
            m.dmap[2] = 16'h2000;
        end
        return m;
    endfunction

endpackage

// File: rtl/seg_xlate_regs.sv
module seg_xlate_regs
    import seg_xlate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      legacy_i,
    input  logic      wr_en_i,
    input  logic [15:0] wr_addr_i,
    input  map_word_t wr_data_i,
    output map_file_t maps_o
);

    map_file_t maps_d, maps_q;

    always_comb begin
        maps_d = maps_q;
        if (!rst_n) begin
            maps_d = boot_maps(legacy_i);
        end else if (wr_en_i) begin
            for (int k = 0; k < NUM_IMAP; k++) begin
                if (wr_addr_i == WIN_IMAP + 16'(2 * k)) maps_d.imap[k] = wr_data_i;
            end
            for (int k = 0; k < NUM_DMAP; k++) begin
                if (wr_addr_i == WIN_DMAP + 16'(2 * k)) maps_d.dmap[k] = wr_data_i;
            end
            // shadow address of one data map: same storage, second decode
            if (wr_addr_i == WIN_DMAP2_ALIAS) maps_d.dmap[ALIAS_IDX] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        maps_q <= maps_d;
    end

    assign maps_o = maps_q;

endmodule

// File: rtl/seg_xlate_dpath.sv
module seg_xlate_dpath
    import seg_xlate_pkg::*;
#(
    parameter int BLK_LG = 14
) (
    input  logic [23:0]               off_i,
    input  map_word_t [NUM_DMAP-1:0]  dmap_i,
    output xlate_t                    res_o
);

    localparam int          IDX_W     = $clog2(NUM_DMAP);
    localparam int          SPAN_LG   = BLK_LG + IDX_W;
    localparam logic [31:0] BLK_BYTES = 32'(1) << BLK_LG;

    logic [IDX_W-1:0] idx;
    logic [31:0]      boff;
    map_word_t        m;
    logic [1:0]       quarter;
    logic [3:0]       shamt;
    logic [3:0]       io_seg;
    logic [9:0]       segno;
    logic             unused_bits;

    assign unused_bits = ^{m[14], m[11:10]};

    always_comb begin
        idx     = off_i[SPAN_LG-1:BLK_LG];
        boff    = 32'(off_i[BLK_LG-1:0]);
        m       = dmap_i[idx];
        quarter = 2'(boff >> 12);
        shamt   = {2'(2'd3 - quarter), 2'b00};
        io_seg  = 4'(m >> shamt);
        segno   = m[9:0];

        res_o.fault = 1'b0;
        res_o.phys  = '0;
        res_o.room  = BLK_BYTES - boff;

        if (off_i[23:SPAN_LG] != '0) begin
            res_o.fault = 1'b1;
        end else if (m[15]) begin
            res_o.phys = BASE_DAT + {12'h000, io_seg, 16'h0000} + IO_WINDOW + boff;
        end else begin
            case (m[13:12])
                2'b00:   res_o.phys = BASE_UNI + (32'(segno) << BLK_LG) + boff;
                2'b01:   res_o.phys = BASE_INS + (32'(segno) << BLK_LG) + boff;
                2'b10:   res_o.phys = BASE_DAT + (32'(segno) << 16)
                                    + (32'(idx) << BLK_LG) + boff;
                default: res_o.fault = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/seg_xlate_ipath.sv
module seg_xlate_ipath
    import seg_xlate_pkg::*;
#(
    parameter int BLK_LG  = 17,
    parameter int TEST_LG = 11
) (
    input  logic [23:0]               off_i,
    input  map_word_t [NUM_IMAP-1:0]  imap_i,
    output xlate_t                    res_o
);

    localparam int          IDX_W      = $clog2(NUM_IMAP);
    localparam int          SPAN_LG    = BLK_LG + IDX_W;
    localparam logic [31:0] BLK_BYTES  = 32'(1) << BLK_LG;
    localparam logic [31:0] TEST_BYTES = 32'(1) << TEST_LG;

    logic [IDX_W-1:0]   idx;
    logic [31:0]        boff;
    logic [TEST_LG-1:0] toff;
    map_word_t          m;
    logic               unused_bits;

    assign unused_bits = ^{m[15:14], m[11:7]};

    always_comb begin
        idx  = off_i[SPAN_LG-1:BLK_LG];
        boff = 32'(off_i[BLK_LG-1:0]);
        toff = off_i[TEST_LG-1:0];
        m    = imap_i[idx];

        res_o.fault = 1'b0;
        res_o.phys  = '0;
        res_o.room  = BLK_BYTES - boff;

        if (off_i[23:SPAN_LG] != '0) begin
            res_o.fault = 1'b1;
        end else begin
            case (m[13:12])
                2'b00: res_o.phys = BASE_UNI + (32'(m[6:0]) << BLK_LG) + boff;
                2'b01: res_o.phys = BASE_INS + (32'(idx) << BLK_LG) + boff;
                2'b11: begin
                    res_o.phys = BASE_INS + 32'(toff);
                    res_o.room = TEST_BYTES - 32'(toff);
                end
                default: res_o.fault = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int LEN_W   = 18,
    parameter int DBLK_LG = 14,
    parameter int IBLK_LG = 17,
    parameter int PSEG_LG = 17,
    parameter int TEST_LG = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             legacy_i,
    input  logic [31:0]      addr_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             wr_en_i,
    input  logic [15:0]      wr_addr_i,
    input  logic [15:0]      wr_data_i,
    output logic [31:0]      phys_o,
    output logic [LEN_W-1:0] grant_o,
    output logic             fault_o
);

    localparam logic [31:0] PSEG_BYTES = 32'(1) << PSEG_LG;

    map_file_t   maps_q;
    xlate_t      dres, ires, pick;
    logic [7:0]  sel;
    logic [23:0] off;

    assign sel = addr_i[31:24];
    assign off = addr_i[23:0];

    seg_xlate_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .legacy_i  (legacy_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .maps_o    (maps_q)
    );

    seg_xlate_dpath #(.BLK_LG(DBLK_LG)) u_dpath (
        .off_i  (off),
        .dmap_i (maps_q.dmap),
        .res_o  (dres)
    );

    seg_xlate_ipath #(.BLK_LG(IBLK_LG), .TEST_LG(TEST_LG)) u_ipath (
        .off_i  (off),
        .imap_i (maps_q.imap),
        .res_o  (ires)
    );

    always_comb begin
        case (sel)
            SEL_PHYS_UNI, SEL_PHYS_INS, SEL_PHYS_DAT: begin
                pick.fault = 1'b0;
                pick.phys  = addr_i;
                pick.room  = PSEG_BYTES - 32'(addr_i[PSEG_LG-1:0]);
            end
            SEL_LOG_DAT: pick = dres;
            SEL_LOG_INS: pick = ires;
            default: begin
                pick.fault = 1'b1;
                pick.phys  = '0;
                pick.room  = '0;
            end
        endcase

        if (pick.fault) begin
            fault_o = 1'b1;
            phys_o  = '0;
            grant_o = '0;
        end else begin
            fault_o = 1'b0;
            phys_o  = pick.phys;
            grant_o = (32'(len_i) > pick.room) ? LEN_W'(pick.room) : len_i;
        end
    end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_xlate_pkg::*;
#(
    parameter int LEN_W   = 18,
    parameter int IBLK_LG = 17,
    parameter int PSEG_LG = 17,
    parameter int TEST_LG = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      addr_i,
    input logic [LEN_W-1:0] len_i,
    input logic             wr_en_i,
    input logic [15:0]      wr_addr_i,
    input logic [15:0]      wr_data_i,
    input logic [31:0]      phys_o,
    input logic [LEN_W-1:0] grant_o,
    input logic             fault_o,
    input map_file_t        maps
);

    logic sel_phys, sel_known, alias_hit;

    always_comb begin
        sel_phys  = (addr_i[31:24] == SEL_PHYS_UNI) || (addr_i[31:24] == SEL_PHYS_INS)
                 || (addr_i[31:24] == SEL_PHYS_DAT);
        sel_known = sel_phys || (addr_i[31:24] == SEL_LOG_DAT) || (addr_i[31:24] == SEL_LOG_INS);
        alias_hit = (addr_i[31:24] == SEL_LOG_INS) && (addr_i[23:IBLK_LG+1] == '0)
                 && (maps.imap[addr_i[IBLK_LG]][13:12] == 2'b11);
    end

    p_bad_sel_faults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_known |-> fault_o);

    p_phys_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_phys |-> (!fault_o && phys_o == addr_i));

    p_phys_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_phys |-> (32'(addr_i[PSEG_LG-1:0]) + 32'(grant_o) <= (32'(1) << PSEG_LG)));

    p_grant_within_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o <= len_i);

    p_test_alias_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alias_hit |-> (!fault_o && (phys_o >> TEST_LG) == (BASE_INS >> TEST_LG)
                       && 32'(grant_o) <= (32'(1) << TEST_LG)));

    p_fault_zeroes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (grant_o == '0 && phys_o == '0));

    p_idle_holds_maps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(maps));

    p_shadow_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == WIN_DMAP2_ALIAS) |=> maps.dmap[ALIAS_IDX] == $past(wr_data_i));

endmodule

bind seg_xlate seg_xlate_chk #(
    .LEN_W   (LEN_W),
    .IBLK_LG (IBLK_LG),
    .PSEG_LG (PSEG_LG),
    .TEST_LG (TEST_LG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr_i),
    .len_i     (len_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .phys_o    (phys_o),
    .grant_o   (grant_o),
    .fault_o   (fault_o),
    .maps      (maps_q)
);

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        legacy_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [17:0] len_i = '0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [31:0] phys_o;
    logic [17:0] grant_o;
    logic        fault_o;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    logic [15:0] m_imap [2];
    logic [15:0] m_dmap [4];

    always #5 clk = ~clk;

    seg_xlate dut (
        .clk(clk), .rst_n(rst_n), .legacy_i(legacy_i),
        .addr_i(addr_i), .len_i(len_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .phys_o(phys_o), .grant_o(grant_o), .fault_o(fault_o)
    );

    function automatic void model(input logic [31:0] a, input int unsigned l,
                                  output logic f, output logic [31:0] p, output int unsigned g);
        int unsigned o, room, r, bo, n, io, tb;
        logic [15:0] m;
        o = a[23:0];
        f = 0; p = 0; room = 0;
        case (a[31:24])
            8'h00, 8'h01, 8'h02: begin
                p = a;
                room = 32'h20000 - (o % 32'h20000);
            end
            8'h10: begin
                if (o >= 32'h10000) f = 1;
                else begin
                    r = o / 32'h4000; bo = o % 32'h4000; room = 32'h4000 - bo;
                    m = m_dmap[r];
                    if (m[15]) begin
                        n = (bo / 32'h1000) % 4;
                        io = (32'(m) >> (4 * (3 - n))) & 32'hF;
                        p = 32'h0200_0000 + io * 32'h10000 + 32'hC000 + bo;
                    end else begin
                        case (m[13:12])
                            2'd0: p = 32'(m[9:0]) * 32'h4000 + bo;
                            2'd1: p = 32'h0100_0000 + 32'(m[9:0]) * 32'h4000 + bo;
                            2'd2: p = 32'h0200_0000 + (32'(m[9:0]) << 16) + r * 32'h4000 + bo;
                            default: f = 1;
                        endcase
                    end
                end
            end
            8'h11: begin
                if (o >= 32'h40000) f = 1;
                else begin
                    r = o / 32'h20000; bo = o % 32'h20000; room = 32'h20000 - bo;
                    m = m_imap[r];
                    case (m[13:12])
                        2'd0: p = (32'(m[6:0]) << 17) + bo;
                        2'd1: p = 32'h0100_0000 + r * 32'h20000 + bo;
                        2'd3: begin
                            tb = bo % 32'h800;
                            p = 32'h0100_0000 + tb;
                            room = 32'h800 - tb;
                        end
                        default: f = 1;
                    endcase
                end
            end
            default: f = 1;
        endcase
        if (f) begin p = 0; g = 0; end
        else g = (l > room) ? room : l;
    endfunction

    task automatic apply_reset(input logic legacy);
        @(negedge clk);
        rst_n = 1'b0; legacy_i = legacy;
        m_dmap[0] = 16'h2000; m_dmap[1] = 16'h2000; m_dmap[3] = 16'h0000;
        if (legacy) begin
            m_imap[0] = 16'h0000; m_imap[1] = 16'h007F; m_dmap[2] = 16'h0000;
        end else begin
            m_imap[0] = 16'h1000; m_imap[1] = 16'h1000; m_dmap[2] = 16'h2000;
        end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic win_write(input logic [15:0] wa, input logic [15:0] wd);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = wa; wr_data_i = wd;
        case (wa)
            16'hFF00: m_imap[0] = wd;
            16'hFF02: m_imap[1] = wd;
            16'hFF08: m_dmap[0] = wd;
            16'hFF0A: m_dmap[1] = wd;
            16'hFF04, 16'hFF0C: m_dmap[2] = wd;
            16'hFF0E: m_dmap[3] = wd;
            default: ;
        endcase
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic check_x(input logic [31:0] a, input int unsigned l, input string tag);
        logic ef; logic [31:0] ep; int unsigned eg;
        @(negedge clk);
        addr_i = a; len_i = l[17:0];
        #1;
        model(a, l, ef, ep, eg);
        n_checks++;
        if (fault_o !== ef || phys_o !== ep || grant_o !== eg[17:0]) begin
            n_err++;
            $display("FAIL %s addr=%h len=%0d actual fault=%b phys=%h grant=%0d expected fault=%b phys=%h grant=%0d",
                     tag, a, l, fault_o, phys_o, grant_o, ef, ep, eg);
        end
    endtask

    // probe one address in each of the six map blocks
    task automatic probe_all(input string tag);
        check_x(32'h1000_0010, 8,  tag);
        check_x(32'h1000_5020, 8,  tag);
        check_x(32'h1000_9030, 8,  tag);
        check_x(32'h1000_C040, 8,  tag);
        check_x(32'h1100_0100, 16, tag);
        check_x(32'h1102_0200, 16, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0]  sels [8];
        logic [15:0] wins [10];
        void'($urandom(32'd4242));
        sels = '{8'h00, 8'h01, 8'h02, 8'h10, 8'h11, 8'h03, 8'h12, 8'hFF};
        wins = '{16'hFF00, 16'hFF02, 16'hFF04, 16'hFF06, 16'hFF08,
                 16'hFF0A, 16'hFF0C, 16'hFF0E, 16'hFF10, 16'h0000};

        // R11: normal reset values seen through translation
        apply_reset(1'b0);
        probe_all("R11 reset state");

        // R1: passthrough and unsupported selectors
        check_x(32'h0212_3456, 4, "R1 phys data");
        check_x(32'h0000_0000, 1, "R1 phys unified");
        check_x(32'h0500_0000, 4, "R1 R8 bad selector");
        check_x(32'h1200_0000, 4, "R1 R8 bad selector");
        // R2: clamp at physical segment boundary
        check_x(32'h011F_FFF0, 32'h40, "R2 phys clamp");
        check_x(32'h0002_0000, 32'h3FFFF, "R2 phys full segment");
        // R3: logical data range and block clamp
        check_x(32'h1001_0000, 4, "R3 R8 data out of range");
        check_x(32'h1000_3FF0, 32'h100, "R3 data block clamp");
        // R9 / R4: data map spaces
        win_write(16'hFF0A, 16'h1005);
        win_write(16'hFF08, 16'h0003);
        win_write(16'hFF0E, 16'h3000);
        probe_all("R9 R4 data map targets");
        check_x(32'h1000_C000, 4, "R4 R8 reserved space");
        win_write(16'hFF08, 16'h2123);
        check_x(32'h1000_1234, 4, "R4 internal data");
        // R5: I/O path, each quarter of the block
        win_write(16'hFF0A, 16'h8ABC);
        check_x(32'h1000_4123, 4, "R5 io quarter 0");
        check_x(32'h1000_5123, 4, "R5 io quarter 1");
        check_x(32'h1000_6FFE, 8, "R5 io quarter 2");
        check_x(32'h1000_7FF0, 64, "R5 io quarter 3 clamp");
        // R10: shadow address and ignored addresses
        win_write(16'hFF04, 16'h2001);
        check_x(32'h1000_8010, 4, "R10 shadow write");
        win_write(16'hFF06, 16'h3000);
        win_write(16'hFF10, 16'h3000);
        probe_all("R10 stray writes ignored");
        // R6: instruction maps
        win_write(16'hFF02, 16'h0005);
        check_x(32'h1102_0040, 8, "R6 insn unified");
        win_write(16'hFF00, 16'h2000);
        check_x(32'h1100_0040, 8, "R6 R8 insn reserved");
        check_x(32'h1104_0000, 8, "R6 R8 insn out of range");
        win_write(16'hFF02, 16'h1000);
        check_x(32'h1103_FFF8, 32'h100, "R6 insn block clamp");
        // R7: test alias
        win_write(16'hFF00, 16'h3000);
        check_x(32'h1100_17F0, 32'h40, "R7 test alias clamp");
        check_x(32'h1100_0805, 4, "R7 test alias wrap");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] s;
            int unsigned o, l;
            if ($urandom % 4 == 0) win_write(wins[$urandom % 10], 16'($urandom));
            s = sels[$urandom % 8];
            if ($urandom % 8 == 0) o = $urandom & 32'hFFFFFF;
            else if (s == 8'h11) o = $urandom % 32'h40000;
            else o = $urandom % 32'h20000;
            l = ($urandom % 4 == 0) ? ($urandom % 32'h40000) : ($urandom % 32'h100);
            check_x({s, o[23:0]}, l, "RND");
        end

        // R12: legacy reset values
        apply_reset(1'b1);
        probe_all("R12 legacy reset state");
        apply_reset(1'b0);
        probe_all("R11 reset after legacy");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule